// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is an up/down counter for position sensing, driven through a small register bus. It can count the system clock or follow the two phases, A and B, of an incremental quadrature encoder. A and B are asynchronous pins. Each is resynchronised before its edges are detected.

A 2-bit mode field chooses the count source:
- **Mode 0** counts the internal clock.
- **Mode 1** counts both edges of A. The level of B sets the direction.
- **Mode 2** counts both edges of B. The level of A sets the direction.
- **Mode 3** counts every edge of either phase, which gives four counts per encoder cycle.

The count runs between zero and a programmable ceiling and wraps at either end. Each wrap gives a one-cycle update pulse.

Software can:
- read and write the count;
- enable or pause counting;
- choose whether a new ceiling applies at once or waits in a shadow register;
- force an update event that moves the shadow ceiling into service;
- read the direction of the last step.

Top module: `qenc_timer`

## Requirements
- R1: After reset the control register reads 0, the count reads 0, the active ceiling reads all ones (0xFFFF for 16 bits) and the status register reads 0. Address map: 0 = control, 1 = count, 2 = ceiling, 3 = status/event. Control fields: bit 0 enable, bit 1 ceiling buffering, bits 3:2 mode.
- R2: In mode 0 with enable set, the count rises by one on every clock edge. Clearing enable freezes the count.
- R3: In mode 1, each rising or falling edge of A steps the count. The count goes up when A and B differ after the edge and down when they match. Edges on B leave the count unchanged.
- R4: In mode 2, each edge of B steps the count. The count goes up when A and B match after the edge and down when they differ. Edges on A leave the count unchanged.
- R5: In mode 3, every edge of A follows the R3 rule and every edge of B follows the R4 rule. A full cycle with A leading B therefore adds 4, and with B leading subtracts 4.
- R6: In mode 3, when A and B both change in the same synchronised sample, the count is left unchanged.
- R7: A step up from a count equal to or above the active ceiling gives 0. It also gives a one-cycle pulse on `update_o`.
- R8: A step down from 0 gives the active ceiling and a one-cycle pulse on `update_o`.
- R9: With buffering clear, a ceiling write takes effect at once. With buffering set, it is held in a shadow register until the next wrap or forced update.
- R10: Writing 1 to bit 0 of the status/event address copies the shadow ceiling into service and pulses `update_o` on the next cycle. Bit 0 always reads 0.
- R11: Status bit 1 and `dir_o` show the direction of the last step: 0 up, 1 down.
- R12: A write to the count address loads the count on the next edge. This holds in any mode, whether enabled or not, and the write wins over a simultaneous step.
- R13: With enable clear, encoder edges leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Direction of the last step, 1 = down |
| update_o | output | 1 | One-cycle pulse on wrap or forced update |

## Verification
Some properties are checked on every cycle:
- a count write lands on the next edge;
- a paused counter stays still;
- a double-edge sample in mode 3 leaves the count alone;
- a forced update pulses `update_o`;
- any count change other than plus or minus one, without a write, comes with an update pulse.

The direction rules of each encoder mode need the bench's waveform sequences. So do the deferral of a buffered ceiling until a wrap or forced update, and the exact wrap targets.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // register addresses (low bits of bus_addr)
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_COUNT = 1;
  localparam int unsigned A_CEIL  = 2;
  localparam int unsigned A_STAT  = 3;

  // control field positions
  localparam int unsigned C_EN      = 0;
  localparam int unsigned C_BUF     = 1;
  localparam int unsigned C_MODE_LO = 2;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_BOTH = 2'd3
  } src_mode_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2,
  parameter int CH     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] raw_i,
  output logic [CH-1:0] lvl_o,
  output logic [CH-1:0] edge_o
);
  generate
    for (genvar c = 0; c < CH; c++) begin : g_ch
      logic [STAGES-1:0] pipe;
      logic              prev;
      if (STAGES == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (rst) pipe <= '0;
          else     pipe <= raw_i[c];
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (rst) pipe <= '0;
          else     pipe <= {pipe[STAGES-2:0], raw_i[c]};
        end
      end
      always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= pipe[STAGES-1];
      end
      assign lvl_o[c]  = pipe[STAGES-1];
      assign edge_o[c] = pipe[STAGES-1] ^ prev;
    end
  endgenerate
endmodule

// File: rtl/qenc_stepper.sv
module qenc_stepper
  import qenc_pkg::*;
(
  input  src_mode_e  mode_i,
  input  logic       en_i,
  input  logic [1:0] lvl_i,   // [0]=A, [1]=B
  input  logic [1:0] edge_i,
  output logic       step_o,
  output logic       up_o
);
  logic differ;
  assign differ = lvl_i[0] ^ lvl_i[1];

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (mode_i)
      SRC_CLK: begin
        step_o = en_i;
        up_o   = 1'b1;
      end
      SRC_A: begin
        step_o = en_i & edge_i[0];
        up_o   = differ;
      end
      SRC_B: begin
        step_o = en_i & edge_i[1];
        up_o   = ~differ;
      end
      SRC_BOTH: begin
        if (edge_i == 2'b01) begin
          step_o = en_i;
          up_o   = differ;
        end else if (edge_i == 2'b10) begin
          step_o = en_i;
          up_o   = ~differ;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wd_i,
  input  logic             ceil_we_i,
  input  logic [CNT_W-1:0] ceil_wd_i,
  input  logic             buffered_i,
  input  logic             force_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] ceil_o,
  output logic             dir_o,
  output logic             update_o
);
  logic [CNT_W-1:0] ceil_shd;
  logic [CNT_W-1:0] nxt;
  logic             wrap;
  logic             reload;

  always_comb begin
    if (up_i) begin
      wrap = (count_o >= ceil_o);
      nxt  = wrap ? '0 : count_o + 1'b1;
    end else begin
      wrap = (count_o == '0);
      nxt  = wrap ? ceil_o : count_o - 1'b1;
    end
  end

  assign reload = (step_i & wrap & ~cnt_we_i) | force_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o  <= '0;
      dir_o    <= 1'b0;
      update_o <= 1'b0;
    end else begin
      update_o <= reload;
      if (cnt_we_i) begin
        count_o <= cnt_wd_i;
      end else if (step_i) begin
        count_o <= nxt;
        dir_o   <= ~up_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ceil_o   <= '1;
      ceil_shd <= '1;
    end else begin
      if (reload) ceil_o <= ceil_shd;
      if (ceil_we_i) begin
        ceil_shd <= ceil_wd_i;
        if (!buffered_i) ceil_o <= ceil_wd_i;
      end
    end
  end
endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  ceil_i,
  input  logic              dir_i,
  output logic              en_o,
  output logic              buffered_o,
  output src_mode_e         mode_o,
  output logic              cnt_we_o,
  output logic              ceil_we_o,
  output logic [CNT_W-1:0]  wval_o,
  output logic              force_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SEL_W = 2;
  logic [SEL_W-1:0] sel;
  assign sel = addr_i[SEL_W-1:0];

  logic hit_ctrl, hit_stat;
  assign hit_ctrl  = we_i && (sel == SEL_W'(A_CTRL));
  assign cnt_we_o  = we_i && (sel == SEL_W'(A_COUNT));
  assign ceil_we_o = we_i && (sel == SEL_W'(A_CEIL));
  assign hit_stat  = we_i && (sel == SEL_W'(A_STAT));
  assign force_o   = hit_stat && wdata_i[0];
  assign wval_o    = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o       <= 1'b0;
      buffered_o <= 1'b0;
      mode_o     <= SRC_CLK;
    end else if (hit_ctrl) begin
      en_o       <= wdata_i[C_EN];
      buffered_o <= wdata_i[C_BUF];
      mode_o     <= src_mode_e'(wdata_i[C_MODE_LO +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      unique case (sel)
        SEL_W'(A_CTRL):  rdata_o <= DATA_W'({mode_o, buffered_o, en_o});
        SEL_W'(A_COUNT): rdata_o <= DATA_W'(count_i);
        SEL_W'(A_CEIL):  rdata_o <= DATA_W'(ceil_i);
        default:         rdata_o <= DATA_W'({dir_i, 1'b0});
      endcase
    end
  end
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qenc_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              enc_a,
  input  logic              enc_b,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_o,
  output logic              update_o
);
  logic [1:0]       enc_lvl, enc_edges;
  logic             run_en, buffered, cnt_we, ceil_we, force_upd;
  logic             step, step_up;
  logic [CNT_W-1:0] wval, ceil_act;
  src_mode_e        mode_sel;

  qenc_sync #(.STAGES(SYNC_STAGES), .CH(2)) sync_i (
    .clk(clk), .rst(rst), .raw_i({enc_b, enc_a}),
    .lvl_o(enc_lvl), .edge_o(enc_edges)
  );

  qenc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
    .count_i(count_o), .ceil_i(ceil_act), .dir_i(dir_o),
    .en_o(run_en), .buffered_o(buffered), .mode_o(mode_sel),
    .cnt_we_o(cnt_we), .ceil_we_o(ceil_we), .wval_o(wval),
    .force_o(force_upd), .rdata_o(bus_rdata)
  );

  qenc_stepper step_i (
    .mode_i(mode_sel), .en_i(run_en), .lvl_i(enc_lvl), .edge_i(enc_edges),
    .step_o(step), .up_o(step_up)
  );

  qenc_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .step_i(step), .up_i(step_up),
    .cnt_we_i(cnt_we), .cnt_wd_i(wval), .ceil_we_i(ceil_we), .ceil_wd_i(wval),
    .buffered_i(buffered), .force_i(force_upd),
    .count_o(count_o), .ceil_o(ceil_act), .dir_o(dir_o), .update_o(update_o)
  );
endmodule

// File: rtl/qenc_timer_chk.sv
module qenc_timer_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  count_o,
  input logic              update_o,
  input logic              run_en,
  input logic [1:0]        mode_sel,
  input logic [1:0]        enc_edges
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic wr_cnt, wr_evt;
  assign wr_cnt = bus_we && (bus_addr[1:0] == 2'd1);
  assign wr_evt = bus_we && (bus_addr[1:0] == 2'd3) && bus_wdata[0];

  // R12
  count_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (count_o == $past(bus_wdata[CNT_W-1:0])));

  // R13
  paused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_cnt) |=> $stable(count_o));

  // R6
  double_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && mode_sel == 2'd3 && enc_edges == 2'b11 && !wr_cnt) |=> $stable(count_o));

  // R10
  force_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> update_o);

  // R7
  jump_means_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_cnt) && (count_o != $past(count_o)) &&
     (count_o != $past(count_o) + ONE) && (count_o != $past(count_o) - ONE)) |-> update_o);
endmodule

bind qenc_timer qenc_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .count_o(count_o), .update_o(update_o), .run_en(run_en), .mode_sel(mode_sel),
  .enc_edges(enc_edges)
);

// File: tb/qenc_timer_tb.sv
`timescale 1ns/1ps
module qenc_timer_tb_top;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              enc_a = 1'b0;
  logic              enc_b = 1'b0;
  logic [CNT_W-1:0]  count_o;
  logic              dir_o;
  logic              update_o;

  always #2.5 clk = ~clk;

  qenc_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b), .count_o(count_o),
    .dir_o(dir_o), .update_o(update_o)
  );

  typedef struct {
    int          src;   // 0 rdata, 1 count_o, 2 update pulses, 3 dir_o
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  smp_ev;
  int    n_run = 0;
  int    n_fail = 0;
  int    upd_seen = 0;
  int    upd_exp = 0;
  bit    done = 1'b0;

  always @(negedge clk) if (!rst && update_o) upd_seen++;

  // monitor: pops expectations and compares with live values
  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb_q.pop_front();
        case (it.src)
          0: got = bus_rdata;
          1: got = 32'(count_o);
          2: got = 32'(upd_seen);
          default: got = 32'(dir_o);
        endcase
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic exp_rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    sb_q.push_back('{0, e, tag});
    @(posedge clk);
    #1;
    -> smp_ev;
  endtask

  task automatic exp_sig(input int src, input logic [31:0] e, input string tag);
    @(negedge clk);
    sb_q.push_back('{src, e, tag});
    -> smp_ev;
    #0.1;
  endtask

  task automatic enc(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    exp_rd(0, 32'h0, "R1 ctrl");
    exp_rd(1, 32'h0, "R1 count");
    exp_rd(2, 32'hFFFF, "R1 ceiling");
    exp_rd(3, 32'h0, "R1 status");

    // R2 free counting: 11 edges with enable set
    wr(0, 32'h1);
    repeat (9) @(negedge clk);
    wr(0, 32'h0);
    exp_rd(1, 32'd11, "R2 clock count");
    repeat (6) @(negedge clk);
    exp_sig(1, 32'd11, "R2 frozen when disabled");

    // R3 mode 1
    wr(1, 32'd100);
    wr(0, 32'h5);
    enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
    exp_sig(1, 32'd102, "R3 A edges up, B ignored");
    enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
    exp_sig(1, 32'd100, "R3 A edges down");
    exp_sig(3, 32'd1, "R11 dir after down");

    // R4 mode 2
    wr(0, 32'h9);
    enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
    exp_sig(1, 32'd102, "R4 B edges up, A ignored");
    exp_sig(3, 32'd0, "R11 dir after up");

    // R5 mode 3
    wr(0, 32'hD);
    enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
    exp_sig(1, 32'd106, "R5 x4 forward");
    enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
    exp_sig(1, 32'd102, "R5 x4 backward");

    // R6 simultaneous edges
    enc(1, 1); enc(0, 0);
    exp_sig(1, 32'd102, "R6 double edge ignored");

    // R7 wrap up
    wr(0, 32'hC);
    wr(2, 32'd5);
    wr(1, 32'd4);
    wr(0, 32'hD);
    enc(1, 0);
    exp_sig(1, 32'd5, "R7 reach ceiling");
    enc(1, 1);
    upd_exp = 1;
    exp_sig(1, 32'd0, "R7 wrap to zero");
    exp_sig(2, 32'(upd_exp), "R7 update pulse");

    // R8 wrap down
    enc(1, 0);
    upd_exp++;
    exp_sig(1, 32'd5, "R8 wrap to ceiling");
    exp_sig(2, 32'(upd_exp), "R8 update pulse");

    // R9 buffered ceiling
    wr(0, 32'hF);
    wr(2, 32'd9);
    exp_rd(2, 32'd5, "R9 buffered write deferred");
    enc(1, 1);
    upd_exp++;
    exp_sig(1, 32'd0, "R9 wrap at old ceiling");
    exp_rd(2, 32'd9, "R9 shadow loaded on wrap");
    wr(0, 32'hD);
    wr(2, 32'd7);
    exp_rd(2, 32'd7, "R9 unbuffered immediate");

    // R10 forced update
    wr(0, 32'hF);
    wr(2, 32'd3);
    exp_rd(2, 32'd7, "R10 before force");
    wr(3, 32'h1);
    upd_exp++;
    exp_rd(2, 32'd3, "R10 shadow loaded by force");
    exp_rd(3, 32'h0, "R10 force bit reads 0");
    exp_sig(2, 32'(upd_exp), "R10 update pulse");

    // R11 direction in status
    enc(1, 0);
    upd_exp++;
    exp_sig(1, 32'd3, "R8 wrap to new ceiling");
    exp_rd(3, 32'h2, "R11 status dir down");

    // R12 count writes
    wr(1, 32'd2);
    exp_rd(1, 32'd2, "R12 write while enabled");

    // R13 disabled encoder
    wr(0, 32'hC);
    enc(1, 1); enc(0, 1);
    exp_sig(1, 32'd2, "R13 edges ignored when disabled");
    wr(0, 32'h0);
    wr(1, 32'd7);
    exp_rd(1, 32'd7, "R12 write in mode 0 disabled");
    exp_sig(2, 32'(upd_exp), "R7 total update pulses");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule